// File: doc/BRIEF.md
# Dual-Channel Host I/O Write Snooper

This block sits beside a host I/O bus decoder and listens for write cycles aimed at two programmable 16-bit port addresses. A typical use is catching the boot-progress codes that firmware writes to a fixed diagnostic port. Each channel keeps the last byte written to its port and flags that capture in a shared status register. The flags can drive a single level interrupt toward a local management processor.

Host writes arrive already decoded: a one-cycle valid strobe with a 16-bit address and an 8-bit byte. The local side sees a flat 32-bit register file with a combinational read port and a one-cycle write strobe. Capture flags are cleared by writing ones. A build-time option adds a second per-channel gate register, which must also be set before a channel captures.

Top module: `iow_snoop`

## Requirements
- R1: After reset every mapped register (control 0x00, status 0x04, ports 0x10, data 0x14, gate 0x80) reads zero and `irq` is low.
- R2: A host write with `host_wr_vld` high captures its byte one clock later when all of these hold: the channel's snoop enable is set, the address equals the channel's port, and (if the gate option is built in) the channel's gate bit is set. Channel 0's port sits in bits 15:0 of 0x10 and channel 1's in bits 31:16. Channel 0's byte is read at bits 7:0 of 0x14 and channel 1's at bits 15:8.
- R3: A host write to any other address, or to a disabled channel, leaves the captured bytes and status bits unchanged.
- R4: A capture sets the channel's status bit, bit 0 for channel 0 and bit 1 for channel 1 of 0x04. Writing a 1 to a status bit clears it, and writing a 0 leaves it as it is.
- R5: If a capture and a clear of the same status bit fall in the same cycle, the bit ends set and the byte holds the new value.
- R6: A later capture on a channel overwrites that channel's byte.
- R7: Both channels can be pending together, and a single read of 0x14 then returns both bytes.
- R8: `irq` is high exactly when some channel has both its status bit and its interrupt enable set, and it stays high until those bits are cleared. Control register 0x00 bit 0 is the channel 0 snoop enable, bit 1 its interrupt enable, bit 2 the channel 1 snoop enable and bit 3 its interrupt enable.
- R9: The control bits 3:0 and all 32 bits of the port register read back as written, and the other control bits read zero.
- R10: With the gate option built in, 0x80 bit 14 gates channel 0 and bit 15 gates channel 1, and both bits read back as written. Without the option, 0x80 reads zero and gating plays no part.
- R11: Unmapped offsets read zero and ignore writes, and writes to the data register 0x14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_vld | input | 1 | Host I/O write strobe, one cycle per write |
| host_wr_addr | input | 16 | Host I/O port address |
| host_wr_data | input | 8 | Host write byte |
| reg_addr | input | 8 | Local register byte offset |
| reg_wr_en | input | 1 | Local register write strobe |
| reg_wdata | input | 32 | Local register write data |
| reg_rdata | output | 32 | Local register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A broken comparator or a bad enable gate shows up at 0x14 and 0x04 in the clock after the offending host write, as a missed capture or a wrong one. If the capture-versus-clear priority is reversed, the status bit reads zero right after a collision cycle. A stale pending bit, or a wrong interrupt-enable bit position, shows on `irq` in the same cycle that it reaches the status register. A wrong decode of the packed fields swaps or corrupts the bytes in the first read that follows a capture on both channels.

// File: rtl/iow_snoop_pkg.sv
package iow_snoop_pkg;
   localparam int NCH = 2;
   localparam int CTRL_STRIDE = 2;
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_PORT = 8'h10;
   localparam logic [7:0] OFS_DATA = 8'h14;
   localparam logic [7:0] OFS_GATE = 8'h80;
   localparam int GATE_LSB = 14;
endpackage

// File: rtl/iow_snoop_chan.sv
module iow_snoop_chan #(
   parameter int HOST_AW = 16,
   parameter int HOST_DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_vld,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [HOST_DW-1:0] host_data,
   input  logic               snoop_en,
   input  logic               gate_ok,
   input  logic [HOST_AW-1:0] port,
   input  logic               clr,
   output logic [HOST_DW-1:0] cap_data,
   output logic               pend
);
   logic hit;
   assign hit = host_vld && snoop_en && gate_ok && (host_addr == port);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_data <= '0;
         pend     <= 1'b0;
      end else begin
         if (hit) cap_data <= host_data;
         if (hit)      pend <= 1'b1;
         else if (clr) pend <= 1'b0;
      end
   end

   assert_capture_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend);
   assert_capture_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cap_data == $past(host_data)));
   assert_no_hit_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_data));
   assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !pend);
endmodule

// File: rtl/iow_snoop_regs.sv
module iow_snoop_regs
   import iow_snoop_pkg::*;
#(
   parameter int HOST_AW  = 16,
   parameter int HOST_DW  = 8,
   parameter int REG_AW   = 8,
   parameter int REG_DW   = 32,
   parameter bit HAS_GATE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [REG_AW-1:0]             reg_addr,
   input  logic                          reg_wr_en,
   input  logic [REG_DW-1:0]             reg_wdata,
   input  logic [NCH-1:0]                pend,
   input  logic [NCH-1:0][HOST_DW-1:0]   cap_data,
   output logic [NCH-1:0]                snoop_en,
   output logic [NCH-1:0]                int_en,
   output logic [NCH-1:0]                gate_ok,
   output logic [NCH-1:0][HOST_AW-1:0]   port,
   output logic [NCH-1:0]                clr,
   output logic [REG_DW-1:0]             reg_rdata
);
   localparam int CTRL_W = NCH * CTRL_STRIDE;

   logic [CTRL_W-1:0] ctrl_q;
   logic [NCH-1:0]    gate_rd;
   logic sel_ctrl, sel_stat, sel_port, sel_data, sel_gate, unmapped;

   assign sel_ctrl = (reg_addr == REG_AW'(OFS_CTRL));
   assign sel_stat = (reg_addr == REG_AW'(OFS_STAT));
   assign sel_port = (reg_addr == REG_AW'(OFS_PORT));
   assign sel_data = (reg_addr == REG_AW'(OFS_DATA));
   assign sel_gate = (reg_addr == REG_AW'(OFS_GATE));
   assign unmapped = !(sel_ctrl || sel_stat || sel_port || sel_data || sel_gate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         port   <= '0;
      end else if (reg_wr_en) begin
         if (sel_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (sel_port) port   <= reg_wdata[NCH*HOST_AW-1:0];
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ctrl
      assign snoop_en[i] = ctrl_q[i*CTRL_STRIDE];
      assign int_en[i]   = ctrl_q[i*CTRL_STRIDE+1];
      assign clr[i]      = reg_wr_en && sel_stat && reg_wdata[i];
   end

   if (HAS_GATE) begin : g_gate
      logic [NCH-1:0] gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate_q <= '0;
         else if (reg_wr_en && sel_gate) gate_q <= reg_wdata[GATE_LSB +: NCH];
      end
      assign gate_ok = gate_q;
      assign gate_rd = gate_q;
   end else begin : g_nogate
      assign gate_ok = '1;
      assign gate_rd = '0;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) reg_rdata[CTRL_W-1:0] = ctrl_q;
      if (sel_stat) reg_rdata[NCH-1:0] = pend;
      if (sel_port) reg_rdata[NCH*HOST_AW-1:0] = port;
      if (sel_data) reg_rdata[NCH*HOST_DW-1:0] = cap_data;
      if (sel_gate) reg_rdata[GATE_LSB +: NCH] = gate_rd;
   end

   assert_unmapped_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (unmapped || sel_data)) |=> ($stable(ctrl_q) && $stable(port)));
   assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (reg_rdata == '0));
endmodule

// File: rtl/iow_snoop.sv
module iow_snoop
   import iow_snoop_pkg::*;
#(
   parameter int HOST_AW  = 16,
   parameter int HOST_DW  = 8,
   parameter int REG_AW   = 8,
   parameter int REG_DW   = 32,
   parameter bit HAS_GATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr_vld,
   input  logic [HOST_AW-1:0] host_wr_addr,
   input  logic [HOST_DW-1:0] host_wr_data,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_wr_en,
   input  logic [REG_DW-1:0]  reg_wdata,
   output logic [REG_DW-1:0]  reg_rdata,
   output logic               irq
);
   if (NCH * HOST_AW > REG_DW) begin : g_chk_port
      $error("packed port fields exceed register width");
   end
   if (NCH * HOST_DW > REG_DW || GATE_LSB + NCH > REG_DW) begin : g_chk_data
      $error("packed data or gate fields exceed register width");
   end
   if (REG_AW < 8) begin : g_chk_aw
      $error("register address too narrow for the offset map");
   end

   logic [NCH-1:0]              snoop_en, int_en, gate_ok, clr, pend;
   logic [NCH-1:0][HOST_AW-1:0] port;
   logic [NCH-1:0][HOST_DW-1:0] cap_data;

   iow_snoop_regs #(
      .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .REG_AW(REG_AW),
      .REG_DW(REG_DW), .HAS_GATE(HAS_GATE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .pend(pend), .cap_data(cap_data),
      .snoop_en(snoop_en), .int_en(int_en), .gate_ok(gate_ok), .port(port),
      .clr(clr), .reg_rdata(reg_rdata)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      iow_snoop_chan #(.HOST_AW(HOST_AW), .HOST_DW(HOST_DW)) u_chan (
         .clk(clk), .rst_n(rst_n), .host_vld(host_wr_vld),
         .host_addr(host_wr_addr), .host_data(host_wr_data),
         .snoop_en(snoop_en[i]), .gate_ok(gate_ok[i]), .port(port[i]),
         .clr(clr[i]), .cap_data(cap_data[i]), .pend(pend[i])
      );
   end

   assign irq = |(pend & int_en);

   assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && clr == '0 && !reg_wr_en) |=> irq);
   assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq);
endmodule

// File: tb/iow_snoop_test.sv
module iow_snoop_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_vld = 1'b0;
   logic [15:0] host_wr_addr = '0;
   logic [7:0]  host_wr_data = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, flat_rdata;
   logic        irq, flat_irq;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   iow_snoop #(.HAS_GATE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr_vld(host_wr_vld),
      .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   iow_snoop #(.HAS_GATE(1'b0)) uut_flat (
      .clk(clk), .rst_n(rst_n), .host_wr_vld(host_wr_vld),
      .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(flat_rdata), .irq(flat_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr_addr = a; host_wr_data = d; host_wr_vld = 1'b1;
      @(negedge clk);
      host_wr_vld = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      reg_rd(8'h00, v); check("R1 ctrl", v, 0);
      reg_rd(8'h04, v); check("R1 status", v, 0);
      reg_rd(8'h10, v); check("R1 ports", v, 0);
      reg_rd(8'h14, v); check("R1 data", v, 0);
      reg_rd(8'h80, v); check("R1 gate", v, 0);
      check("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_config();
      logic [31:0] v;
      reg_wr(8'h00, 32'hFFFF_FFFF);
      reg_rd(8'h00, v); check("R9 ctrl readback", v, 32'h0000_000F);
      reg_wr(8'h10, 32'hBEEF_0080);
      reg_rd(8'h10, v); check("R9 port readback", v, 32'hBEEF_0080);
      reg_wr(8'h80, 32'hFFFF_FFFF);
      reg_rd(8'h80, v); check("R10 gate readback", v, 32'h0000_C000);
      #1 check("R10 gate absent reads zero", flat_rdata, 0);
      reg_wr(8'h00, 32'h0000_0005);
   endtask

   task automatic t_capture();
      logic [31:0] v;
      host_wr(16'h0080, 8'h12);
      reg_rd(8'h14, v); check("R2 ch0 byte", v, 32'h0000_0012);
      reg_rd(8'h04, v); check("R4 status set", v, 32'h1);
      check("R8 no irq without enable", {31'd0, irq}, 0);
   endtask

   task automatic t_mismatch();
      logic [31:0] v;
      host_wr(16'h0081, 8'h55);
      reg_rd(8'h14, v); check("R3 other address", v, 32'h0000_0012);
      reg_wr(8'h00, 32'h0000_0001);
      host_wr(16'hBEEF, 8'h66);
      reg_rd(8'h14, v); check("R3 disabled channel byte", v, 32'h0000_0012);
      reg_rd(8'h04, v); check("R3 disabled channel status", v, 32'h1);
      reg_wr(8'h00, 32'h0000_0005);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      reg_wr(8'h80, 32'h0000_8000);
      host_wr(16'h0080, 8'h77);
      reg_rd(8'h14, v); check("R10 gate closed", v, 32'h0000_0012);
      #1 check("R10 no gate option captures", flat_rdata, 32'h0000_0077);
      reg_wr(8'h80, 32'h0000_C000);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      reg_wr(8'h04, 32'h0);
      reg_rd(8'h04, v); check("R4 write zero keeps", v, 32'h1);
      reg_wr(8'h04, 32'h1);
      reg_rd(8'h04, v); check("R4 write one clears", v, 32'h0);
   endtask

   task automatic t_overwrite();
      logic [31:0] v;
      host_wr(16'h0080, 8'h21);
      host_wr(16'h0080, 8'h34);
      reg_rd(8'h14, v); check("R6 overwrite", v, 32'h0000_0034);
   endtask

   task automatic t_both();
      logic [31:0] v;
      host_wr(16'hBEEF, 8'hAB);
      reg_rd(8'h14, v); check("R7 both bytes", v, 32'h0000_AB34);
      reg_rd(8'h04, v); check("R7 both pending", v, 32'h3);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      reg_wr(8'h00, 32'h0000_000F);
      #1 check("R8 irq set", {31'd0, irq}, 1);
      reg_wr(8'h04, 32'h1);
      #1 check("R8 irq held by ch1", {31'd0, irq}, 1);
      reg_wr(8'h04, 32'h2);
      #1 check("R8 irq cleared", {31'd0, irq}, 0);
      reg_wr(8'h00, 32'h0000_000D);
      host_wr(16'h0080, 8'h40);
      #1 check("R8 ch0 masked", {31'd0, irq}, 0);
      host_wr(16'hBEEF, 8'h41);
      #1 check("R8 ch1 raises", {31'd0, irq}, 1);
      reg_wr(8'h04, 32'h3);
      reg_rd(8'h04, v); check("R4 clear both", v, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      @(negedge clk);
      host_wr_addr = 16'h0080; host_wr_data = 8'h99; host_wr_vld = 1'b1;
      reg_addr = 8'h04; reg_wdata = 32'h1; reg_wr_en = 1'b1;
      @(negedge clk);
      host_wr_vld = 1'b0; reg_wr_en = 1'b0;
      reg_rd(8'h04, v); check("R5 capture wins status", v, 32'h1);
      reg_rd(8'h14, v); check("R5 capture wins byte", v, 32'h0000_4199);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      reg_wr(8'h08, 32'hFFFF_FFFF);
      reg_rd(8'h08, v); check("R11 unmapped reads zero", v, 0);
      reg_rd(8'h00, v); check("R11 ctrl untouched", v, 32'h0000_000D);
      reg_wr(8'h14, 32'h0);
      reg_rd(8'h14, v); check("R11 data write ignored", v, 32'h0000_4199);
      reg_wr(8'h12, 32'h0);
      reg_rd(8'h10, v); check("R11 ports untouched", v, 32'hBEEF_0080);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_capture();
      t_mismatch();
      t_gate();
      t_w1c();
      t_overwrite();
      t_both();
      t_irq();
      t_race();
      t_unmapped();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule